// File: doc/BRIEF.md
# Disk File Address Counter

This block holds the 16-bit address of the disk record that a transfer works on and steps it forward as the transfer moves from one sector to the next. The address word packs, from the least significant bit upward, a 5-bit sector number (0 to 28), a disk bit (1 selects the fixed platter, 0 the cartridge), a surface bit (0 top, 1 bottom) and a 9-bit cylinder number. A controller writes a new word with a one-cycle load strobe. The block checks the word against the sector limit and against the cylinder limit of the attached drive: 202 for the small drive and 405 for the large one. A word that passes is taken, and a one-cycle seek strobe goes out with the cylinder on the track address lines. A word that fails is dropped and raises the address error flag. Every load is acknowledged either way.

During a multi-sector transfer, each sector-done pulse advances the address by one sector. Past sector 28 the sector wraps to 0 and the surface flips. When the surface wraps from bottom back to top, the cylinder steps. The disk bit is never touched by stepping. If a step would take the cylinder beyond the drive's limit, the block keeps the address, raises the error flag, pulses a transfer-abort output and ignores further sector-done pulses until a valid load arrives.

A small state machine sequences this work. It has three states:
- `ST_READY`: idle or stepping.
- `ST_SEEK`: the one cycle after a valid load, in which the seek strobe is high.
- `ST_HALTED`: entered after a cylinder overrun.

Its transitions are:
- READY or SEEK to SEEK on a valid load.
- READY or SEEK to HALTED on an overrunning step.
- READY or SEEK to READY otherwise.
- HALTED to SEEK on a valid load.
- HALTED to HALTED otherwise.

Top module: `disk_addr_ctr`

## Requirements
- R1: After reset all address fields are 0, `addr_err`, `seek_strobe`, `load_ack` and `xfer_abort` are 0.
- R2: A valid load updates `sector`, `disk_fixed`, `surface` and `cylinder` from `load_word` bits 4:0, 5, 6 and 15:7 in the cycle after the strobe, and `load_ack` is high in that cycle.
- R3: A valid load raises `seek_strobe` for exactly one cycle, the cycle after the strobe, with `track_addr` equal to the loaded cylinder.
- R4: A load whose sector field exceeds 28 sets `addr_err`, leaves every address field unchanged, gives no seek strobe and is still acknowledged on `load_ack`.
- R5: The cylinder limit is 202 when `drive_large` is 0 and 405 when it is 1; a loaded cylinder above the limit is rejected as in R4, and one equal to it is accepted.
- R6: A `sector_done` pulse adds one to the sector in the next cycle, and the cylinder changes only on a load or a `sector_done`.
- R7: A step from sector 28 with the surface at top (0) gives sector 0 and surface bottom (1), with the cylinder kept.
- R8: A step from sector 28 with the surface at bottom (1) gives sector 0, surface top (0) and cylinder plus one.
- R9: The disk bit changes only on a valid load, never on a step.
- R10: A step from sector 28, surface bottom, at the cylinder limit keeps the address, sets `addr_err` and pulses `xfer_abort` for one cycle; later `sector_done` pulses are ignored until a valid load.
- R11: `addr_err` stays set through steps and rejected loads and clears only in the cycle after a valid load.
- R12: When a load strobe and `sector_done` arrive in the same cycle, the load wins and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_large | input | 1 | 1 = 406-cylinder drive, 0 = 203-cylinder drive |
| load_valid | input | 1 | One-cycle load strobe |
| load_word | input | 16 | Address word to load |
| sector_done | input | 1 | One-cycle pulse at the end of each transferred sector |
| sector | output | 5 | Current sector |
| disk_fixed | output | 1 | Current disk bit |
| surface | output | 1 | Current surface bit |
| cylinder | output | 9 | Current cylinder |
| seek_strobe | output | 1 | One-cycle seek strobe after a valid load |
| track_addr | output | 9 | Cylinder presented to the drive |
| addr_err | output | 1 | Address error flag |
| load_ack | output | 1 | Reply to every load, one cycle after it |
| xfer_abort | output | 1 | One-cycle pulse ending a transfer on cylinder overrun |

## Verification
Every result of this block is registered once, so the address fields, `load_ack`, `seek_strobe`, `addr_err` and `xfer_abort` all respond in the cycle right after the load strobe or `sector_done` pulse that caused them. The seek strobe must then be gone one cycle later. The bench drives each stimulus on a falling edge, holds it over exactly one rising edge and samples on the next falling edge, which is the first point where that single register stage has settled. The strobe's fall and the ignored steps after an overrun are checked on the falling edge after that.

// File: rtl/dac_pkg.sv
package dac_pkg;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_SEEK   = 2'd1,
        ST_HALTED = 2'd2
    } dac_state_t;

endpackage

// File: rtl/dac_load_check.sv
module dac_load_check #(
    parameter int SECT_W     = 5,
    parameter int CYL_W      = 9,
    parameter int SECTOR_MAX = 28
) (
    input  logic [SECT_W-1:0] ld_sector,
    input  logic [CYL_W-1:0]  ld_cyl,
    input  logic [CYL_W-1:0]  cyl_limit,
    output logic              ld_ok
);
    localparam logic [SECT_W-1:0] SMAX = SECT_W'(SECTOR_MAX);

    always_comb begin
        ld_ok = (ld_sector <= SMAX) && (ld_cyl <= cyl_limit);
    end
endmodule

// File: rtl/dac_stepper.sv
module dac_stepper #(
    parameter int SECT_W     = 5,
    parameter int CYL_W      = 9,
    parameter int SECTOR_MAX = 28
) (
    input  logic [SECT_W-1:0] cur_sector,
    input  logic              cur_surface,
    input  logic [CYL_W-1:0]  cur_cyl,
    input  logic [CYL_W-1:0]  cyl_limit,
    output logic [SECT_W-1:0] nxt_sector,
    output logic              nxt_surface,
    output logic [CYL_W-1:0]  nxt_cyl,
    output logic              overrun
);
    localparam logic [SECT_W-1:0] SMAX = SECT_W'(SECTOR_MAX);

    logic sect_wrap;
    logic surf_wrap;

    always_comb begin
        sect_wrap   = (cur_sector == SMAX);
        surf_wrap   = sect_wrap && cur_surface;
        nxt_sector  = sect_wrap ? '0 : cur_sector + 1'b1;
        nxt_surface = sect_wrap ? ~cur_surface : cur_surface;
        nxt_cyl     = surf_wrap ? cur_cyl + 1'b1 : cur_cyl;
        overrun     = surf_wrap && (cur_cyl >= cyl_limit);
    end
endmodule

// File: rtl/disk_addr_ctr.sv
module disk_addr_ctr
    import dac_pkg::*;
#(
    parameter int SECT_W       = 5,
    parameter int CYL_W        = 9,
    parameter int SECTOR_MAX   = 28,
    parameter int CYL_MAX_SMALL = 202,
    parameter int CYL_MAX_LARGE = 405,
    localparam int ADDR_W      = CYL_W + SECT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_large,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_word,
    input  logic              sector_done,
    output logic [SECT_W-1:0] sector,
    output logic              disk_fixed,
    output logic              surface,
    output logic [CYL_W-1:0]  cylinder,
    output logic              seek_strobe,
    output logic [CYL_W-1:0]  track_addr,
    output logic              addr_err,
    output logic              load_ack,
    output logic              xfer_abort
);
    localparam int DISK_BIT = SECT_W;
    localparam int SURF_BIT = SECT_W + 1;
    localparam int CYL_LSB  = SECT_W + 2;
    localparam logic [CYL_W-1:0] LIM_S = CYL_W'(CYL_MAX_SMALL);
    localparam logic [CYL_W-1:0] LIM_L = CYL_W'(CYL_MAX_LARGE);

    dac_state_t state_q, state_d;

    logic [SECT_W-1:0] sect_q;
    logic              disk_q, surf_q;
    logic [CYL_W-1:0]  cyl_q;
    logic              err_q, ack_q, abort_q;

    logic [CYL_W-1:0]  cyl_limit;
    logic              ld_ok;
    logic [SECT_W-1:0] st_sector;
    logic              st_surface;
    logic [CYL_W-1:0]  st_cyl;
    logic              overrun;
    logic              ld_take, ld_reject, step_req, step_take, step_fail;

    assign cyl_limit = drive_large ? LIM_L : LIM_S;

    dac_load_check #(
        .SECT_W(SECT_W), .CYL_W(CYL_W), .SECTOR_MAX(SECTOR_MAX)
    ) u_check (
        .ld_sector (load_word[SECT_W-1:0]),
        .ld_cyl    (load_word[ADDR_W-1:CYL_LSB]),
        .cyl_limit (cyl_limit),
        .ld_ok     (ld_ok)
    );

    dac_stepper #(
        .SECT_W(SECT_W), .CYL_W(CYL_W), .SECTOR_MAX(SECTOR_MAX)
    ) u_step (
        .cur_sector  (sect_q),
        .cur_surface (surf_q),
        .cur_cyl     (cyl_q),
        .cyl_limit   (cyl_limit),
        .nxt_sector  (st_sector),
        .nxt_surface (st_surface),
        .nxt_cyl     (st_cyl),
        .overrun     (overrun)
    );

    always_comb begin
        ld_take   = load_valid && ld_ok;
        ld_reject = load_valid && !ld_ok;
        step_req  = !load_valid && sector_done && (state_q != ST_HALTED);
        step_take = step_req && !overrun;
        step_fail = step_req && overrun;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY, ST_SEEK: begin
                if (ld_take)        state_d = ST_SEEK;
                else if (step_fail) state_d = ST_HALTED;
                else                state_d = ST_READY;
            end
            ST_HALTED: begin
                if (ld_take)        state_d = ST_SEEK;
                else                state_d = ST_HALTED;
            end
            default:                state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // address and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q  <= '0;
            disk_q  <= 1'b0;
            surf_q  <= 1'b0;
            cyl_q   <= '0;
            err_q   <= 1'b0;
            ack_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            ack_q   <= load_valid;
            abort_q <= step_fail;
            if (ld_take) begin
                sect_q <= load_word[SECT_W-1:0];
                disk_q <= load_word[DISK_BIT];
                surf_q <= load_word[SURF_BIT];
                cyl_q  <= load_word[ADDR_W-1:CYL_LSB];
            end else if (step_take) begin
                sect_q <= st_sector;
                surf_q <= st_surface;
                cyl_q  <= st_cyl;
            end
            if (ld_take)                    err_q <= 1'b0;
            else if (ld_reject || step_fail) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        seek_strobe = (state_q == ST_SEEK);
        track_addr  = cyl_q;
        sector      = sect_q;
        disk_fixed  = disk_q;
        surface     = surf_q;
        cylinder    = cyl_q;
        addr_err    = err_q;
        load_ack    = ack_q;
        xfer_abort  = abort_q;
    end
endmodule

// File: rtl/disk_addr_ctr_chk.sv
module disk_addr_ctr_chk #(
    parameter int SECT_W     = 5,
    parameter int CYL_W      = 9,
    parameter int SECTOR_MAX = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_valid,
    input logic              sector_done,
    input logic [SECT_W-1:0] sector,
    input logic              disk_fixed,
    input logic [CYL_W-1:0]  cylinder,
    input logic              seek_strobe,
    input logic              addr_err,
    input logic              load_ack,
    input logic              xfer_abort
);
    localparam logic [SECT_W-1:0] SMAX = SECT_W'(SECTOR_MAX);

    assert_ack_every_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> load_ack);

    assert_strobe_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seek_strobe |-> $past(load_valid));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_strobe && !load_valid) |=> !seek_strobe);

    assert_strobe_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seek_strobe |-> load_ack);

    assert_disk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |=> $stable(disk_fixed));

    assert_cyl_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_valid && !sector_done) |=> $stable(cylinder));

    assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_err) |-> $past(load_valid));

    assert_abort_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> addr_err);

    assert_sector_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sector <= SMAX);
endmodule

bind disk_addr_ctr disk_addr_ctr_chk #(
    .SECT_W(SECT_W), .CYL_W(CYL_W), .SECTOR_MAX(SECTOR_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_valid  (load_valid),
    .sector_done (sector_done),
    .sector      (sector),
    .disk_fixed  (disk_fixed),
    .cylinder    (cylinder),
    .seek_strobe (seek_strobe),
    .addr_err    (addr_err),
    .load_ack    (load_ack),
    .xfer_abort  (xfer_abort)
);

// File: tb/tb_disk_addr_ctr.sv
module tb_disk_addr_ctr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drive_large = 1'b1;
    logic        load_valid = 1'b0;
    logic [15:0] load_word = '0;
    logic        sector_done = 1'b0;
    logic [4:0]  sector;
    logic        disk_fixed, surface, seek_strobe, addr_err, load_ack, xfer_abort;
    logic [8:0]  cylinder, track_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    disk_addr_ctr dut (
        .clk(clk), .rst_n(rst_n), .drive_large(drive_large),
        .load_valid(load_valid), .load_word(load_word), .sector_done(sector_done),
        .sector(sector), .disk_fixed(disk_fixed), .surface(surface),
        .cylinder(cylinder), .seek_strobe(seek_strobe), .track_addr(track_addr),
        .addr_err(addr_err), .load_ack(load_ack), .xfer_abort(xfer_abort)
    );

    function automatic logic [15:0] mk(int cyl, int surf, int dsk, int sec);
        return {cyl[8:0], surf[0], dsk[0], sec[4:0]};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_addr(string req, int sec, int dsk, int surf, int cyl);
        chk(req, "sector", sector, sec);
        chk(req, "disk", disk_fixed, dsk);
        chk(req, "surface", surface, surf);
        chk(req, "cylinder", cylinder, cyl);
    endtask

    task automatic do_load(logic [15:0] w);
        @(negedge clk);
        load_valid = 1'b1; load_word = w;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        sector_done = 1'b1;
        @(negedge clk);
        sector_done = 1'b0;
    endtask

    task automatic t_reset();
        chk_addr("R1", 0, 0, 0, 0);
        chk("R1", "addr_err", addr_err, 0);
        chk("R1", "seek_strobe", seek_strobe, 0);
        chk("R1", "load_ack", load_ack, 0);
        chk("R1", "xfer_abort", xfer_abort, 0);
    endtask

    task automatic t_valid_load();
        do_load(mk(100, 0, 1, 5));
        chk_addr("R2", 5, 1, 0, 100);
        chk("R2", "load_ack", load_ack, 1);
        chk("R3", "seek_strobe", seek_strobe, 1);
        chk("R3", "track_addr", track_addr, 100);
        @(negedge clk);
        chk("R3", "seek_strobe low", seek_strobe, 0);
        chk("R2", "load_ack low", load_ack, 0);
    endtask

    task automatic t_step_plain();
        do_step();
        chk_addr("R6", 6, 1, 0, 100);
        chk("R6", "no strobe", seek_strobe, 0);
    endtask

    task automatic t_wrap_surface();
        do_load(mk(10, 0, 0, 28));
        do_step();
        chk_addr("R7", 0, 0, 1, 10);
    endtask

    task automatic t_wrap_cylinder();
        do_load(mk(10, 1, 1, 28));
        do_step();
        chk_addr("R8", 0, 1, 0, 11);
        chk("R9", "disk kept", disk_fixed, 1);
    endtask

    task automatic t_bad_sector();
        do_load(mk(50, 1, 0, 29));
        chk_addr("R4", 0, 1, 0, 11);
        chk("R4", "addr_err", addr_err, 1);
        chk("R4", "load_ack", load_ack, 1);
        chk("R4", "no strobe", seek_strobe, 0);
        do_step();
        chk("R11", "err held on step", addr_err, 1);
        chk("R6", "step after reject", sector, 1);
        do_load(mk(20, 0, 0, 3));
        chk("R11", "err cleared", addr_err, 0);
        chk_addr("R11", 3, 0, 0, 20);
    endtask

    task automatic t_limits();
        drive_large = 1'b0;
        do_load(mk(203, 0, 0, 0));
        chk("R5", "small 203 err", addr_err, 1);
        chk("R5", "small 203 cyl kept", cylinder, 20);
        do_load(mk(202, 0, 0, 0));
        chk("R5", "small 202 ok", addr_err, 0);
        chk("R5", "small 202 cyl", cylinder, 202);
        drive_large = 1'b1;
        do_load(mk(406, 0, 0, 0));
        chk("R5", "large 406 err", addr_err, 1);
        chk("R5", "large 406 cyl kept", cylinder, 202);
        do_load(mk(405, 0, 0, 0));
        chk("R5", "large 405 ok", addr_err, 0);
        chk("R5", "large 405 cyl", cylinder, 405);
    endtask

    task automatic t_overrun();
        do_load(mk(405, 1, 1, 28));
        do_step();
        chk_addr("R10", 28, 1, 1, 405);
        chk("R10", "addr_err", addr_err, 1);
        chk("R10", "xfer_abort", xfer_abort, 1);
        @(negedge clk);
        chk("R10", "abort one cycle", xfer_abort, 0);
        do_step();
        chk_addr("R10", 28, 1, 1, 405);
        chk("R10", "no abort on ignored step", xfer_abort, 0);
        do_load(mk(7, 0, 0, 2));
        chk("R11", "err cleared after halt", addr_err, 0);
        chk("R11", "strobe after halt", seek_strobe, 1);
        do_step();
        chk("R10", "steps resume", sector, 3);
    endtask

    task automatic t_priority();
        @(negedge clk);
        load_valid = 1'b1; load_word = mk(30, 1, 1, 9); sector_done = 1'b1;
        @(negedge clk);
        load_valid = 1'b0; sector_done = 1'b0;
        chk_addr("R12", 9, 1, 1, 30);
        chk("R12", "strobe", seek_strobe, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_valid_load();
        t_step_plain();
        t_wrap_surface();
        t_wrap_cylinder();
        t_bad_sector();
        t_limits();
        t_overrun();
        t_priority();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule